// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a short burst from one starting address. When a burst opens, the full starting address is captured. The upper bits are then passed through unchanged, and only the low offset field (two bits by default) steps from beat to beat. The ordering of the offsets depends on a select input that is sampled when the burst opens. In interleaved order the offset is the starting offset XORed with the beat number. In linear order the offset is the starting offset plus the beat number, wrapping inside the offset field.

A memory-side controller uses it as follows. It pulses the open strobe with the first address, then raises the step strobe once for each further beat it consumes. The address output is registered state, so it shows the effect of a strobe one clock after the strobe is sampled. Stepping past the last beat returns to the starting offset and never carries into the upper address bits.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low and on the first clock after its release, `addr_o` is all zeros.
- R2: One clock after `start_i` is sampled high, `addr_o` equals the `start_addr_i` value sampled on that edge. This beat is beat 0.
- R3: With `order_sel_i` = 1 at the opening edge (interleaved order), the low two bits after k steps are start XOR k. From starts 00, 01, 10 and 11 the sequences are 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R4: With `order_sel_i` = 0 at the opening edge (linear order), the low two bits after k steps are (start + k) mod 4. From starts 00, 01, 10 and 11 the sequences are 00-01-10-11, 01-10-11-00, 10-11-00-01 and 11-00-01-10.
- R5: Each clock edge with `step_i` high and `start_i` low advances exactly one beat, and the new offset is visible one clock later.
- R6: Between openings, the bits of `addr_o` above the offset field keep the upper bits of the last loaded `start_addr_i`. A step never changes them.
- R7: On an edge with both `start_i` and `step_i` low, `addr_o` does not change.
- R8: The order is held from the opening edge. A change of `order_sel_i` while no burst is being opened has no effect on the offsets that follow.
- R9: After four steps, the offset returns to the starting offset, and the sequence repeats on further steps.
- R10: When `start_i` and `step_i` are both high on one edge, the open wins: `addr_o` becomes the new `start_addr_i` at beat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Open a burst at `start_addr_i` (takes priority over step) |
| step_i | input | 1 | Advance one beat |
| order_sel_i | input | 1 | 1 = interleaved order, 0 = linear order; sampled on open |
| start_addr_i | input | ADDR_W (16) | Starting address of the burst |
| addr_o | output | ADDR_W (16) | Current beat address |

## Verification
The assertions assume that `start_i`, `step_i` and `order_sel_i` are known, driven 0 or 1 values, sampled only on the rising edge. They also assume that the held order register and the beat counter are the only state between strobes, so a step's offset change follows from the held order alone. The bench drives every input one nanosecond after a rising edge and samples the output at the same point after the next edge. Each strobe therefore settles well before the edge that samples it, and each result is read only after the register that carries it has updated.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;

   localparam int unsigned DEF_ADDR_W = 16;
   localparam int unsigned DEF_OFF_W  = 2;

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] beat_o
);

   if (W < 1) begin : g_bad_w
      $error("burst_beat_ctr: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   // Counts modulo 2**W, so the burst wraps inside the offset field.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   assign beat_o = cnt_q;

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
   import burst_seq_pkg::*;
#(
   parameter int unsigned W = 2
) (
   input  logic [W-1:0] base_i,
   input  logic [W-1:0] beat_i,
   input  burst_order_e order_i,
   output logic [W-1:0] off_o
);

   logic [W-1:0] xor_off;
   logic [W-1:0] add_off;

   // Interleaved: each offset bit flips with the matching beat bit.
   for (genvar b = 0; b < W; b++) begin : g_xor_bit
      assign xor_off[b] = base_i[b] ^ beat_i[b];
   end

   // Linear: wrapping add inside the offset field.
   assign add_off = base_i + beat_i;

   always_comb begin
      unique case (order_i)
         ORD_INTERLEAVE: off_o = xor_off;
         default:        off_o = add_off;
      endcase
   end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned OFF_W  = DEF_OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              step_i,
   input  logic              order_sel_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int unsigned HI_W = ADDR_W - OFF_W;

   if (OFF_W < 1) begin : g_bad_off
      $error("burst_seq: OFF_W must be at least 1");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("burst_seq: ADDR_W must exceed OFF_W");
   end

   logic [HI_W-1:0]  hi_q;
   logic [OFF_W-1:0] base_q;
   burst_order_e     mode_q;
   logic [OFF_W-1:0] beat_q;
   logic [OFF_W-1:0] off_w;

   // Capture the burst context on open; hold it otherwise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         base_q <= '0;
         mode_q <= ORD_INTERLEAVE;
      end else if (start_i) begin
         hi_q   <= start_addr_i[ADDR_W-1:OFF_W];
         base_q <= start_addr_i[OFF_W-1:0];
         mode_q <= burst_order_e'(order_sel_i);
      end
   end

   burst_beat_ctr #(.W(OFF_W)) u_beat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (start_i),
      .inc_i  (step_i),
      .beat_o (beat_q)
   );

   burst_offset_map #(.W(OFF_W)) u_map (
      .base_i  (base_q),
      .beat_i  (beat_q),
      .order_i (mode_q),
      .off_o   (off_w)
   );

   assign addr_o = {hi_q, off_w};

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
   import burst_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned OFF_W  = DEF_OFF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              step_i,
   input logic [ADDR_W-1:0] start_addr_i,
   input logic [ADDR_W-1:0] addr_o,
   input burst_order_e      mode_q,
   input logic [OFF_W-1:0]  beat_q
);

   a_r2_open_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (addr_o == $past(start_addr_i)));

   a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && step_i && mode_q == ORD_LINEAR) |=>
         (addr_o[OFF_W-1:0] == OFF_W'($past(addr_o[OFF_W-1:0]) + 1'b1)));

   a_r3_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && step_i && mode_q == ORD_INTERLEAVE) |=>
         ((addr_o[OFF_W-1:0] ^ $past(addr_o[OFF_W-1:0])) == (beat_q ^ $past(beat_q))));

   a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(addr_o[ADDR_W-1:OFF_W]));

   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !step_i) |=> $stable(addr_o));

   a_r8_order_held: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> $stable(mode_q));

   a_r5_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && step_i) |=> (beat_q == OFF_W'($past(beat_q) + 1'b1)));

endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .step_i       (step_i),
   .start_addr_i (start_addr_i),
   .addr_o       (addr_o),
   .mode_q       (mode_q),
   .beat_q       (beat_q)
);

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          step_i = 1'b0;
   logic          order_sel_i = 1'b1;
   logic [AW-1:0] start_addr_i = '0;
   logic [AW-1:0] addr_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   burst_seq #(.ADDR_W(AW), .OFF_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
      .order_sel_i(order_sel_i), .start_addr_i(start_addr_i), .addr_o(addr_o)
   );

   // {order, start offset, beat0..beat3 offsets}
   localparam logic [10:0] VEC [8] = '{
      {1'b1, 2'b00, 8'b00_01_10_11},
      {1'b1, 2'b01, 8'b01_00_11_10},
      {1'b1, 2'b10, 8'b10_11_00_01},
      {1'b1, 2'b11, 8'b11_10_01_00},
      {1'b0, 2'b00, 8'b00_01_10_11},
      {1'b0, 2'b01, 8'b01_10_11_00},
      {1'b0, 2'b10, 8'b10_11_00_01},
      {1'b0, 2'b11, 8'b11_00_01_10}
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [AW-1:0] exp);
      n_tests++;
      if (addr_o !== exp) begin
         n_fail++;
         $display("FAIL %s: addr_o=%h expected=%h", req, addr_o, exp);
      end
   endtask

   task automatic open_burst(input logic ord, input logic [AW-1:0] a);
      start_i = 1'b1; step_i = 1'b0; order_sel_i = ord; start_addr_i = a;
      tick();
      start_i = 1'b0;
   endtask

   task automatic step_once();
      step_i = 1'b1;
      tick();
      step_i = 1'b0;
   endtask

   initial begin
      #200000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [AW-1:0] hi;
      #1;
      check("R1 reset", '0);
      tick(); tick();
      rst_n = 1'b1;
      tick();
      check("R1 after release", '0);

      // Vector walk: R2 open, R3/R4 orders, R5 step, R6 upper, R9 wrap
      for (int i = 0; i < 8; i++) begin
         hi = AW'(16'h1230 + 16'h0404 * i) & 16'hFFFC;
         open_burst(VEC[i][10], hi | AW'(VEC[i][9:8]));
         check("R2 open", hi | AW'(VEC[i][9:8]));
         for (int k = 1; k < 4; k++) begin
            step_once();
            check(VEC[i][10] ? "R3 interleave beat" : "R4 linear beat",
                  hi | AW'(VEC[i][7-2*k -: 2]));
         end
         step_once();
         check("R9 wrap", hi | AW'(VEC[i][9:8]));
         step_once();
         check("R9 repeat", hi | AW'(VEC[i][5:4]));
         check("R6 upper kept", hi | AW'(VEC[i][5:4]));
      end

      // R7: idle cycles hold
      open_burst(1'b0, 16'hBEE1);
      step_once();
      tick(); tick();
      check("R7 idle hold", 16'hBEE2);

      // R8: order change mid-burst ignored (linear from 01: 01,10,11)
      order_sel_i = 1'b1;
      step_once();
      check("R8 order held", 16'hBEE3);
      order_sel_i = 1'b0;
      open_burst(1'b1, 16'h5551);
      order_sel_i = 1'b0;
      step_once();
      check("R8 interleave held", 16'h5550);

      // R10: open and step together, open wins
      start_i = 1'b1; step_i = 1'b1; order_sel_i = 1'b0; start_addr_i = 16'h7772;
      tick();
      start_i = 1'b0; step_i = 1'b0;
      check("R10 open priority", 16'h7772);
      step_once();
      check("R10 then beat1", 16'h7773);

      // R1 again: mid-burst reset
      rst_n = 1'b0;
      #1;
      check("R1 async reset", '0);
      tick();
      rst_n = 1'b1;
      tick();
      check("R1 released", '0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule